// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a single-data-rate SDRAM and owns the command pins from reset until the memory is usable. It first holds the clock enable and the data mask high and drives no-operation commands for a long, parameterised settling period. It then closes both banks with one precharge-all, runs a programmable number of auto-refresh commands, loads the mode register, and raises a sticky ready flag once the mode-load recovery gap has passed.

After that point it keeps the array alive. A free-running interval counter adds one owed refresh every refresh period (about 15.6 µs, so that 2048 refreshes fit in 32 ms). While refreshes are owed and no refresh recovery is running, the block raises a request to the main controller. The controller grants the request only when both banks are idle, and the block then places an auto-refresh on the pins in the next cycle. Owed refreshes pile up, up to a saturation limit, while grants are withheld. A held grant therefore drains them back-to-back, one refresh-cycle time apart. Every wait is a clock count given as a parameter.

Top module: `sdram_boot_refresh`

## Requirements
- R1: While reset is held, and for exactly POWERUP_CLKS cycles after it is released, CKE and DQM are high and the command is NOP. The first command other than NOP appears POWERUP_CLKS cycles after release.
- R2: Commands are encoded on {CS#, RAS#, CAS#, WE#} as follows: NOP = 0111, precharge = 0010, auto refresh = 0001, mode register set = 0000. CKE stays high throughout. In a NOP or auto refresh cycle the address and bank outputs are zero.
- R3: The precharge command closes both banks. The address has bit 10 set and all other bits clear, and the bank output is zero.
- R4: INIT_REFS auto refreshes follow the precharge. The first comes T_RP cycles after the precharge, and each later one comes T_RC cycles after the one before it.
- R5: The mode register set comes T_RC cycles after the last start-up refresh. Its address carries the burst-length code in bits 2:0, the wrap type in bit 3, the latency code in bits 6:4 and the burst-read/single-write flag in bit 9. All other address bits and the bank output are zero.
- R6: The ready flag rises exactly T_MRD cycles after the mode register set and stays high until reset. DQM falls in the same cycle.
- R7: From the cycle ready rises, one owed refresh is added every REFRESH_CLKS cycles. The owed count is presented on owedOut and never exceeds MAX_OWED, where further additions are dropped.
- R8: The request is high exactly when ready is high, no refresh recovery gap is running, and at least one refresh is owed.
- R9: A grant sampled while the request is high puts an auto refresh on the pins in the next cycle and removes one owed refresh. The request then stays low for T_RC cycles, so that consecutive refreshes are at least T_RC apart.
- R10: When a new owed refresh is added on the same clock edge as a refresh is taken, the owed count is unchanged.
- R11: Between scheduled commands the pins carry NOP. A grant given while the request is low issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| grantIn | input | 1 | Main controller permits a refresh (both banks idle) |
| reqOut | output | 1 | Refresh wanted |
| readyOut | output | 1 | Start-up sequence complete, sticky |
| owedOut | output | OWED_W | Number of refreshes owed |
| sdramCke | output | 1 | Clock enable |
| sdramCsN | output | 1 | Chip select, active low |
| sdramRasN | output | 1 | Row strobe, active low |
| sdramCasN | output | 1 | Column strobe, active low |
| sdramWeN | output | 1 | Write enable, active low |
| sdramDqm | output | 1 | Data mask |
| sdramBa | output | BA_W | Bank select |
| sdramAddr | output | ADDR_W | Multiplexed address |

## Verification
Two events can fall on the same clock edge: the interval counter adding an owed refresh, and a granted refresh removing one. The bench provokes this edge on purpose. In one phase it raises the grant only in the cycle whose edge ends a refresh interval. The behavioural model then predicts an owed count that stays the same across that edge, while a refresh still appears on the pins one cycle later. Other phases withhold grants long enough to saturate the count, then hold the grant so that the owed refreshes drain back-to-back. This shows that saturation and draining meet the same count and timing rules.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmdKind_t;

  typedef enum logic [1:0] {
    GAP_RP,
    GAP_RC,
    GAP_MRD
  } gapKind_t;

  typedef enum logic [2:0] {
    ST_POWER,
    ST_PRE_GAP,
    ST_INIT_GAP,
    ST_MRS_GAP,
    ST_IDLE,
    ST_REF_GAP
  } seqState_t;

  typedef struct packed {
    cmdKind_t cmd;
    logic     loadGap;
    gapKind_t gap;
    logic     takeRef;
    logic     goReady;
  } strobe_t;

  // {CS#, RAS#, CAS#, WE#}
  function automatic logic [3:0] cmdPins(input cmdKind_t kind);
    logic [3:0] pins;
    case (kind)
      CMD_PRE: pins = 4'b0010;
      CMD_REF: pins = 4'b0001;
      CMD_MRS: pins = 4'b0000;
      default: pins = 4'b0111;
    endcase
    return pins;
  endfunction

endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import sdram_seq_pkg::*;
#(
  parameter int INIT_REFS = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    grantIn,
  input  logic    waitZero,
  input  logic    owedNz,
  output strobe_t strobe,
  output logic    reqOut
);

  localparam int CNT_W = $clog2(INIT_REFS + 1);
  localparam logic [CNT_W-1:0] REFS_TARGET = CNT_W'(INIT_REFS);

  seqState_t state, stateNext;
  logic [CNT_W-1:0] refsDone, refsDoneNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_POWER;
      refsDone <= '0;
    end else begin
      state    <= stateNext;
      refsDone <= refsDoneNext;
    end
  end

  assign reqOut = (state == ST_IDLE) && owedNz;

  always_comb begin
    stateNext    = state;
    refsDoneNext = refsDone;
    strobe       = '{cmd: CMD_NOP, loadGap: 1'b0, gap: GAP_RP, takeRef: 1'b0, goReady: 1'b0};
    case (state)
      ST_POWER: begin
        if (waitZero) begin
          strobe.cmd     = CMD_PRE;
          strobe.loadGap = 1'b1;
          strobe.gap     = GAP_RP;
          stateNext      = ST_PRE_GAP;
        end
      end
      ST_PRE_GAP: begin
        if (waitZero) begin
          strobe.cmd     = CMD_REF;
          strobe.loadGap = 1'b1;
          strobe.gap     = GAP_RC;
          refsDoneNext   = CNT_W'(1);
          stateNext      = ST_INIT_GAP;
        end
      end
      ST_INIT_GAP: begin
        if (waitZero) begin
          strobe.loadGap = 1'b1;
          if (refsDone >= REFS_TARGET) begin
            strobe.cmd = CMD_MRS;
            strobe.gap = GAP_MRD;
            stateNext  = ST_MRS_GAP;
          end else begin
            strobe.cmd   = CMD_REF;
            strobe.gap   = GAP_RC;
            refsDoneNext = refsDone + 1'b1;
          end
        end
      end
      ST_MRS_GAP: begin
        if (waitZero) begin
          strobe.goReady = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (owedNz && grantIn) begin
          strobe.cmd     = CMD_REF;
          strobe.loadGap = 1'b1;
          strobe.gap     = GAP_RC;
          strobe.takeRef = 1'b1;
          stateNext      = ST_REF_GAP;
        end
      end
      ST_REF_GAP: begin
        if (waitZero) stateNext = ST_IDLE;
      end
      default: stateNext = ST_POWER;
    endcase
  end

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import sdram_seq_pkg::*;
#(
  parameter int POWERUP_CLKS = 20000,
  parameter int T_RP         = 3,
  parameter int T_RC         = 9,
  parameter int T_MRD        = 2,
  parameter int REFRESH_CLKS = 1560,
  parameter int MAX_OWED     = 8,
  parameter int OWED_W       = 4,
  parameter int ADDR_W       = 11,
  parameter int BA_W         = 1,
  parameter int AP_BIT       = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  output logic              waitZero,
  output logic              owedNz,
  output logic [OWED_W-1:0] owedCount,
  output logic              readyFlag,
  output logic [3:0]        cmdBits,
  output logic [BA_W-1:0]   baBits,
  output logic [ADDR_W-1:0] addrBits
);

  localparam int WAIT_MAX = (POWERUP_CLKS > T_RC) ? POWERUP_CLKS : T_RC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int IV_W     = $clog2(REFRESH_CLKS + 1);
  localparam logic [WAIT_W-1:0] LOAD_POWER = WAIT_W'(POWERUP_CLKS - 1);
  localparam logic [WAIT_W-1:0] LOAD_RP    = WAIT_W'(T_RP - 1);
  localparam logic [WAIT_W-1:0] LOAD_RC    = WAIT_W'(T_RC - 1);
  localparam logic [WAIT_W-1:0] LOAD_MRD   = WAIT_W'(T_MRD - 1);
  localparam logic [IV_W-1:0]   LOAD_IV    = IV_W'(REFRESH_CLKS - 1);
  localparam logic [OWED_W-1:0] OWED_TOP   = OWED_W'(MAX_OWED);
  localparam logic [ADDR_W-1:0] AP_WORD    = ADDR_W'(1) << AP_BIT;

  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] gapLoad;
  logic [IV_W-1:0]   ivCnt;
  logic              ivTick;

  // gap countdown between commands
  always_comb begin
    case (strobe.gap)
      GAP_RC:  gapLoad = LOAD_RC;
      GAP_MRD: gapLoad = LOAD_MRD;
      default: gapLoad = LOAD_RP;
    endcase
  end

  assign waitZero = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              waitCnt <= LOAD_POWER;
    else if (strobe.loadGap) waitCnt <= gapLoad;
    else if (!waitZero)     waitCnt <= waitCnt - 1'b1;
  end

  // ready is sticky until reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              readyFlag <= 1'b0;
    else if (strobe.goReady) readyFlag <= 1'b1;
  end

  // refresh interval timer, runs only once ready
  assign ivTick = readyFlag && (ivCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ivCnt <= LOAD_IV;
    else if (readyFlag) ivCnt <= ivTick ? LOAD_IV : ivCnt - 1'b1;
  end

  // owed refresh bookkeeping, saturating
  assign owedNz = (owedCount != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owedCount <= '0;
    end else if (strobe.takeRef) begin
      if (!ivTick) owedCount <= owedCount - 1'b1;
    end else if (ivTick && (owedCount != OWED_TOP)) begin
      owedCount <= owedCount + 1'b1;
    end
  end

  // registered command pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBits  <= cmdPins(CMD_NOP);
      baBits   <= '0;
      addrBits <= '0;
    end else begin
      cmdBits <= cmdPins(strobe.cmd);
      baBits  <= '0;
      case (strobe.cmd)
        CMD_PRE: addrBits <= AP_WORD;
        CMD_MRS: addrBits <= MODE_WORD;
        default: addrBits <= '0;
      endcase
    end
  end

endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh
  import sdram_seq_pkg::*;
#(
  parameter int POWERUP_CLKS = 20000,
  parameter int T_RP         = 3,
  parameter int T_RC         = 9,
  parameter int T_MRD        = 2,
  parameter int INIT_REFS    = 2,
  parameter int REFRESH_CLKS = 1560,
  parameter int MAX_OWED     = 8,
  parameter int ADDR_W       = 11,
  parameter int BA_W         = 1,
  parameter logic [2:0] BURST_CODE = 3'b011,
  parameter logic       WRAP_INTLV = 1'b0,
  parameter logic [2:0] CAS_CODE   = 3'b011,
  parameter logic       BRSW       = 1'b0,
  localparam int OWED_W = $clog2(MAX_OWED + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              grantIn,
  output logic              reqOut,
  output logic              readyOut,
  output logic [OWED_W-1:0] owedOut,
  output logic              sdramCke,
  output logic              sdramCsN,
  output logic              sdramRasN,
  output logic              sdramCasN,
  output logic              sdramWeN,
  output logic              sdramDqm,
  output logic [BA_W-1:0]   sdramBa,
  output logic [ADDR_W-1:0] sdramAddr
);

  localparam logic [ADDR_W-1:0] MODE_WORD =
    {{(ADDR_W-10){1'b0}}, BRSW, 2'b00, CAS_CODE, WRAP_INTLV, BURST_CODE};

  strobe_t    strobe;
  logic       waitZero;
  logic       owedNz;
  logic [3:0] cmdBits;

  seqCtrl #(.INIT_REFS(INIT_REFS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .grantIn (grantIn),
    .waitZero(waitZero),
    .owedNz  (owedNz),
    .strobe  (strobe),
    .reqOut  (reqOut)
  );

  seqDatapath #(
    .POWERUP_CLKS(POWERUP_CLKS),
    .T_RP        (T_RP),
    .T_RC        (T_RC),
    .T_MRD       (T_MRD),
    .REFRESH_CLKS(REFRESH_CLKS),
    .MAX_OWED    (MAX_OWED),
    .OWED_W      (OWED_W),
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .AP_BIT      (10),
    .MODE_WORD   (MODE_WORD)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .waitZero (waitZero),
    .owedNz   (owedNz),
    .owedCount(owedOut),
    .readyFlag(readyOut),
    .cmdBits  (cmdBits),
    .baBits   (sdramBa),
    .addrBits (sdramAddr)
  );

  assign sdramCke = 1'b1;
  assign sdramDqm = ~readyOut;
  assign {sdramCsN, sdramRasN, sdramCasN, sdramWeN} = cmdBits;

endmodule

// File: rtl/sdram_boot_refresh_chk.sv
module sdram_boot_refresh_chk #(
  parameter int MAX_OWED = 8,
  parameter int OWED_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              grantIn,
  input logic              reqOut,
  input logic              readyOut,
  input logic [OWED_W-1:0] owedOut,
  input logic              sdramCsN,
  input logic              sdramRasN,
  input logic              sdramCasN,
  input logic              sdramWeN,
  input logic              sdramDqm
);

  logic [3:0] pins;
  assign pins = {sdramCsN, sdramRasN, sdramCasN, sdramWeN};

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN) readyOut |=> readyOut); // R6
  AST_READY_UNMASK: assert property (@(posedge clk) disable iff (!rstN) readyOut |-> !sdramDqm); // R6
  AST_MRS_BEFORE_READY: assert property (@(posedge clk) disable iff (!rstN) (pins == 4'b0000) |-> !readyOut); // R5
  AST_OWED_LIMIT: assert property (@(posedge clk) disable iff (!rstN) owedOut <= OWED_W'(MAX_OWED)); // R7
  AST_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN) reqOut |-> (readyOut && owedOut != '0)); // R8
  AST_GRANT_ISSUES: assert property (@(posedge clk) disable iff (!rstN) (reqOut && grantIn) |=> (pins == 4'b0001)); // R9
  AST_REF_HOLDOFF: assert property (@(posedge clk) disable iff (!rstN) (readyOut && pins == 4'b0001) |-> !reqOut); // R9

endmodule

bind sdram_boot_refresh sdram_boot_refresh_chk #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_chk (.*);

// File: tb/sdram_boot_refresh_tb.sv
`timescale 1ns/1ps
module sdram_boot_refresh_tb;

  localparam int P     = 30;
  localparam int TRP   = 3;
  localparam int TRC   = 7;
  localparam int TMRD  = 2;
  localparam int NINIT = 2;
  localparam int RCLK  = 40;
  localparam int MAXO  = 4;
  localparam int RUN   = 1300;

  // mode word expected: bits2:0=010, bit3=1, bits6:4=010, bit9=1
  localparam logic [10:0] EXP_MODE = 11'h22A;
  localparam logic [10:0] EXP_AP   = 11'h400;

  localparam logic [3:0] E_NOP = 4'b0111;
  localparam logic [3:0] E_PRE = 4'b0010;
  localparam logic [3:0] E_REF = 4'b0001;
  localparam logic [3:0] E_MRS = 4'b0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grantIn = 1'b0;
  logic reqOut, readyOut;
  logic [2:0] owedOut;
  logic sdramCke, sdramCsN, sdramRasN, sdramCasN, sdramWeN, sdramDqm;
  logic [0:0] sdramBa;
  logic [10:0] sdramAddr;

  always #5 clk = ~clk;

  sdram_boot_refresh #(
    .POWERUP_CLKS(P), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .INIT_REFS(NINIT),
    .REFRESH_CLKS(RCLK), .MAX_OWED(MAXO), .ADDR_W(11), .BA_W(1),
    .BURST_CODE(3'b010), .WRAP_INTLV(1'b1), .CAS_CODE(3'b010), .BRSW(1'b1)
  ) u_dut (
    .clk(clk), .rstN(rstN), .grantIn(grantIn), .reqOut(reqOut), .readyOut(readyOut),
    .owedOut(owedOut), .sdramCke(sdramCke), .sdramCsN(sdramCsN), .sdramRasN(sdramRasN),
    .sdramCasN(sdramCasN), .sdramWeN(sdramWeN), .sdramDqm(sdramDqm), .sdramBa(sdramBa),
    .sdramAddr(sdramAddr)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference schedule
  int preT, firstRefT, mrsT, readyT;
  int t, idleFrom, refT, mOwed, collisions;
  bit lastCollide;

  function automatic logic [3:0] expCmd(input int tt);
    if (tt == preT) return E_PRE;
    if (tt >= firstRefT && tt < mrsT && ((tt - firstRefT) % TRC) == 0) return E_REF;
    if (tt == mrsT) return E_MRS;
    if (tt >= readyT && tt == refT) return E_REF;
    return E_NOP;
  endfunction

  function automatic string cmdTag(input int tt);
    if (tt < preT) return "R1";
    if (tt == preT) return "R3";
    if (tt < mrsT) return "R4";
    if (tt == mrsT) return "R5";
    if (tt >= readyT && tt == refT) return "R9";
    return "R11";
  endfunction

  function automatic bit grantPattern(input int tt);
    int u;
    u = tt - readyT;
    if (u < 0)    return 1'b1;           // grant while request low: ignored (R11)
    if (u < 200)  return 1'b0;           // let owed saturate (R7)
    if (u < 300)  return 1'b1;           // drain back-to-back (R9)
    if (u < 600)  return (u % 3) == 0;
    if (u < 700)  return 1'b0;
    if (u < 1100) return (u % RCLK) == (RCLK - 1); // collide with tick (R10)
    return 1'b1;
  endfunction

  task automatic compareNow();
    logic [3:0] pins;
    logic [3:0] ec;
    logic [10:0] ea;
    bit req;
    pins = {sdramCsN, sdramRasN, sdramCasN, sdramWeN};
    ec = expCmd(t);
    ea = (ec == E_PRE) ? EXP_AP : ((ec == E_MRS) ? EXP_MODE : 11'h000);
    check(cmdTag(t), "command pins", int'(pins), int'(ec));
    check((ec == E_PRE) ? "R3" : ((ec == E_MRS) ? "R5" : "R2"), "address", int'(sdramAddr), int'(ea));
    check("R2", "bank", int'(sdramBa), 0);
    check("R2", "cke", int'(sdramCke), 1);
    check((t < readyT) ? "R1" : "R6", "dqm", int'(sdramDqm), (t < readyT) ? 1 : 0);
    check("R6", "ready", int'(readyOut), (t >= readyT) ? 1 : 0);
    req = (t >= readyT) && (t >= idleFrom) && (mOwed > 0);
    check("R8", "request", int'(reqOut), int'(req));
    check(lastCollide ? "R10" : "R7", "owed", int'(owedOut), mOwed);
  endtask

  task automatic stepModel();
    bit req, tick, issue;
    req   = (t >= readyT) && (t >= idleFrom) && (mOwed > 0);
    tick  = (t >= readyT) && (((t - readyT) % RCLK) == (RCLK - 1));
    issue = req && grantIn;
    if (issue) begin
      mOwed = mOwed - 1 + int'(tick);
      refT = t + 1;
      idleFrom = t + 1 + TRC;
    end else if (tick && mOwed < MAXO) begin
      mOwed = mOwed + 1;
    end
    lastCollide = issue && tick;
    if (lastCollide) collisions++;
    t++;
  endtask

  initial begin : watchdog
    #(20 * RUN * 10);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    preT      = P;
    firstRefT = P + TRP;
    mrsT      = firstRefT + NINIT * TRC;
    readyT    = mrsT + TMRD;
    t = 0; idleFrom = readyT; refT = -1; mOwed = 0; collisions = 0; lastCollide = 0;

    repeat (3) @(negedge clk);
    // reset state (R1)
    check("R1", "reset command", int'({sdramCsN, sdramRasN, sdramCasN, sdramWeN}), int'(E_NOP));
    check("R1", "reset dqm", int'(sdramDqm), 1);
    check("R1", "reset cke", int'(sdramCke), 1);
    check("R6", "reset ready", int'(readyOut), 0);
    rstN = 1'b1;

    for (int i = 0; i < RUN; i++) begin
      compareNow();
      grantIn = grantPattern(t);
      stepModel();
      @(negedge clk);
    end

    check("R10", "tick/issue collisions seen", int'(collisions > 0), 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule